// File: doc/BRIEF.md
# Age-Class Eviction Ranking Unit

This block chooses which line of a cache set to replace on a miss. Each candidate line comes with an age bucket and a one-bit class that marks it as reused or not reused. The block uses the pair (class, age) to index a small table of eviction priorities. It compares the priorities of all candidates and reports the candidate with the highest value as the victim. An update engine outside the block computes the table and rewrites it from time to time through a single write port.

The block also keeps a bank of event counters, one for each combination of event kind (hit or eviction), class and age bucket. The cache reports each hit or eviction together with the line's age and class, and the matching counter counts up by one. A read port selects one counter at a time for the update engine to read. A clear pulse resets the whole bank after each periodic read-out. The counters stop at their maximum value and do not wrap.

Top module: `evict_rank_unit`

## Requirements
- R1: After reset, `victim_valid` is 0, `victim_idx` is 0, every counter reads 0 and every priority entry is 0.
- R2: `victim_valid` is 1 in the cycle after a cycle with `lookup_valid` high, and 0 in the cycle after a cycle with `lookup_valid` low.
- R3: The victim is the candidate whose table entry at (class, age) holds the largest unsigned priority. Candidate i takes its age from `cand_age[3i+2:3i]` and its class from `cand_reused[i]`, where 1 means reused. Age buckets are numbered 0 to 7.
- R4: When two or more candidates share the largest priority, the one with the lowest index wins.
- R5: The reused and non-reused entries for the same age bucket are separate, and each is read only for candidates of its own class.
- R6: A table write takes effect from the next lookup. A lookup in the same cycle as a write uses the old contents.
- R7: An event with `evt_valid` high increments by one the counter selected by `evt_hit` (1 = hit, 0 = eviction), `evt_reused` and `evt_age`. The new value appears on the read port in the next cycle, and no other counter changes.
- R8: A counter that holds 65535 stays at 65535 when further events arrive.
- R9: `cnt_clear` sets every counter to 0 in the next cycle. It takes priority over an event in the same cycle.
- R10: `rd_count` shows, in the same cycle, the counter selected by `rd_hit`, `rd_reused` and `rd_age`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | Miss lookup request |
| cand_age | input | 12 | Age buckets of the four candidates, 3 bits each |
| cand_reused | input | 4 | Class bit of each candidate |
| victim_valid | output | 1 | Victim result valid |
| victim_idx | output | 2 | Index of the chosen victim |
| prio_wr_en | input | 1 | Priority table write enable |
| prio_wr_reused | input | 1 | Class of the entry being written |
| prio_wr_age | input | 3 | Age bucket of the entry being written |
| prio_wr_data | input | 8 | Priority value to write |
| evt_valid | input | 1 | Counter event strobe |
| evt_hit | input | 1 | Event kind: 1 hit, 0 eviction |
| evt_reused | input | 1 | Class of the event's line |
| evt_age | input | 3 | Age bucket of the event's line |
| cnt_clear | input | 1 | Clear all counters |
| rd_hit | input | 1 | Read-port kind select |
| rd_reused | input | 1 | Read-port class select |
| rd_age | input | 3 | Read-port age select |
| rd_count | output | 16 | Selected counter value |

## Verification
The counter properties compare `rd_count` between two consecutive cycles. They apply only when the read select does not change between those cycles, so they assume the read port is the only view of the counter bank. The bench changes the read select only between checks. The victim-valid property assumes that `lookup_valid` is a plain per-cycle strobe with no handshake. The bench raises it for single cycles and holds every other input steady around each lookup, except the same-cycle write case, where the write is deliberate.

// File: rtl/evr_pkg.sv
package evr_pkg;

  // Event kind, used as the top bit of a counter index.
  typedef enum logic {
    EVT_EVICT = 1'b0,
    EVT_HIT   = 1'b1
  } evt_kind_e;

  // Number of classes per age bucket (reused, non-reused).
  localparam int unsigned NUM_CLASSES = 2;
  // Number of event kinds counted.
  localparam int unsigned NUM_KINDS   = 2;

endpackage

// File: rtl/evr_prio_table.sv
module evr_prio_table #(
  parameter int unsigned N_CAND = 4,
  parameter int unsigned N_AGE  = 8,
  parameter int unsigned PRIO_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_reused,
  input  logic [$clog2(N_AGE)-1:0] wr_age,
  input  logic [PRIO_W-1:0]        wr_data,
  input  logic [N_CAND*$clog2(N_AGE)-1:0] rd_age,
  input  logic [N_CAND-1:0]        rd_reused,
  output logic [N_CAND*PRIO_W-1:0] rd_prio
);
  import evr_pkg::*;

  localparam int unsigned AGE_W   = $clog2(N_AGE);
  localparam int unsigned IDX_W   = AGE_W + 1;
  localparam int unsigned ENTRIES = NUM_CLASSES * (1 << AGE_W);

  logic [PRIO_W-1:0] tbl_q [ENTRIES];
  logic [PRIO_W-1:0] tbl_d [ENTRIES];
  logic [IDX_W-1:0]  wr_idx;

  assign wr_idx = {wr_reused, wr_age};

  // Next-state: one entry replaced when the write port is enabled.
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      tbl_d[e] = tbl_q[e];
    end
    if (wr_en) begin
      tbl_d[wr_idx] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tbl_q[e] <= '0;
      end
    end else if (wr_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tbl_q[e] <= tbl_d[e];
      end
    end
  end

  // One read port per candidate, served from the registered contents.
  for (genvar c = 0; c < N_CAND; c++) begin : g_rd
    logic [IDX_W-1:0] rd_idx;
    assign rd_idx = {rd_reused[c], rd_age[c*AGE_W +: AGE_W]};
    assign rd_prio[c*PRIO_W +: PRIO_W] = tbl_q[rd_idx];
  end

endmodule

// File: rtl/evr_victim_select.sv
module evr_victim_select #(
  parameter int unsigned N_CAND = 4,
  parameter int unsigned PRIO_W = 8
) (
  input  logic [N_CAND*PRIO_W-1:0] prio,
  output logic [((N_CAND > 1) ? $clog2(N_CAND) : 1)-1:0] win_idx
);
  localparam int unsigned CAND_W = (N_CAND > 1) ? $clog2(N_CAND) : 1;

  logic [PRIO_W-1:0] best_val;

  // Linear scan; strict compare keeps the lowest index on a tie.
  always_comb begin
    best_val = prio[0 +: PRIO_W];
    win_idx  = '0;
    for (int c = 1; c < N_CAND; c++) begin
      if (prio[c*PRIO_W +: PRIO_W] > best_val) begin
        best_val = prio[c*PRIO_W +: PRIO_W];
        win_idx  = CAND_W'(c);
      end
    end
  end

endmodule

// File: rtl/evr_event_counters.sv
module evr_event_counters #(
  parameter int unsigned N_AGE = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_valid,
  input  logic                     evt_hit,
  input  logic                     evt_reused,
  input  logic [$clog2(N_AGE)-1:0] evt_age,
  input  logic                     clear,
  input  logic                     rd_hit,
  input  logic                     rd_reused,
  input  logic [$clog2(N_AGE)-1:0] rd_age,
  output logic [CNT_W-1:0]         rd_count
);
  import evr_pkg::*;

  localparam int unsigned AGE_W   = $clog2(N_AGE);
  localparam int unsigned CIDX_W  = AGE_W + 2;
  localparam int unsigned NUM_CNT = NUM_KINDS * NUM_CLASSES * (1 << AGE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q [NUM_CNT];
  logic [CIDX_W-1:0] evt_idx;
  logic [CIDX_W-1:0] rd_idx;
  evt_kind_e         evt_kind;

  assign evt_kind = evt_hit ? EVT_HIT : EVT_EVICT;
  assign evt_idx  = {evt_kind, evt_reused, evt_age};
  assign rd_idx   = {rd_hit, rd_reused, rd_age};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic             sel;
    logic             bump;
    logic             en;
    logic [CNT_W-1:0] cnt_d;

    assign sel  = evt_valid && (evt_idx == CIDX_W'(g));
    assign bump = sel && (cnt_q[g] != CNT_MAX);
    assign en   = clear || bump;

    always_comb begin
      if (clear) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q[g] + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else if (en) begin
        cnt_q[g] <= cnt_d;
      end
    end
  end

  assign rd_count = cnt_q[rd_idx];

endmodule

// File: rtl/evict_rank_unit.sv
module evict_rank_unit #(
  parameter int unsigned N_CAND = 4,
  parameter int unsigned N_AGE  = 8,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     lookup_valid,
  input  logic [N_CAND*$clog2(N_AGE)-1:0]          cand_age,
  input  logic [N_CAND-1:0]                        cand_reused,
  output logic                                     victim_valid,
  output logic [((N_CAND > 1) ? $clog2(N_CAND) : 1)-1:0] victim_idx,
  input  logic                                     prio_wr_en,
  input  logic                                     prio_wr_reused,
  input  logic [$clog2(N_AGE)-1:0]                 prio_wr_age,
  input  logic [PRIO_W-1:0]                        prio_wr_data,
  input  logic                                     evt_valid,
  input  logic                                     evt_hit,
  input  logic                                     evt_reused,
  input  logic [$clog2(N_AGE)-1:0]                 evt_age,
  input  logic                                     cnt_clear,
  input  logic                                     rd_hit,
  input  logic                                     rd_reused,
  input  logic [$clog2(N_AGE)-1:0]                 rd_age,
  output logic [CNT_W-1:0]                         rd_count
);
  localparam int unsigned CAND_W = (N_CAND > 1) ? $clog2(N_CAND) : 1;

  logic [N_CAND*PRIO_W-1:0] cand_prio;
  logic [CAND_W-1:0]        win_idx;
  logic                     vld_q, vld_d;
  logic [CAND_W-1:0]        idx_q, idx_d;

  evr_prio_table #(
    .N_CAND (N_CAND),
    .N_AGE  (N_AGE),
    .PRIO_W (PRIO_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (prio_wr_en),
    .wr_reused (prio_wr_reused),
    .wr_age    (prio_wr_age),
    .wr_data   (prio_wr_data),
    .rd_age    (cand_age),
    .rd_reused (cand_reused),
    .rd_prio   (cand_prio)
  );

  evr_victim_select #(
    .N_CAND (N_CAND),
    .PRIO_W (PRIO_W)
  ) u_select (
    .prio    (cand_prio),
    .win_idx (win_idx)
  );

  evr_event_counters #(
    .N_AGE (N_AGE),
    .CNT_W (CNT_W)
  ) u_counters (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_hit    (evt_hit),
    .evt_reused (evt_reused),
    .evt_age    (evt_age),
    .clear      (cnt_clear),
    .rd_hit     (rd_hit),
    .rd_reused  (rd_reused),
    .rd_age     (rd_age),
    .rd_count   (rd_count)
  );

  // Result register: index captured only on a lookup, held otherwise.
  always_comb begin
    vld_d = lookup_valid;
    idx_d = lookup_valid ? win_idx : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (lookup_valid) begin
        idx_q <= idx_d;
      end
    end
  end

  assign victim_valid = vld_q;
  assign victim_idx   = idx_q;

endmodule

// File: rtl/evr_checker.sv
module evr_checker #(
  parameter int unsigned AGE_W = 3,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lookup_valid,
  input logic             victim_valid,
  input logic             cnt_clear,
  input logic             rd_hit,
  input logic             rd_reused,
  input logic [AGE_W-1:0] rd_age,
  input logic [CNT_W-1:0] rd_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [AGE_W+1:0] rd_sel;
  assign rd_sel = {rd_hit, rd_reused, rd_age};

  // R2: result strobe follows the request by one cycle
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> victim_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !victim_valid);

  // R9: a clear empties whichever counter is being read
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (rd_count == '0));

  // R7: without a clear, a watched counter never drops and rises by at most one
  p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_sel) && !$past(cnt_clear)) |->
      ((rd_count >= $past(rd_count)) &&
       ({1'b0, rd_count} <= ({1'b0, $past(rd_count)} + 1'b1))));

  // R8: a full counter stays full until cleared
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_sel) && !$past(cnt_clear) && ($past(rd_count) == CMAX)) |->
      (rd_count == CMAX));

endmodule

bind evict_rank_unit evr_checker #(
  .AGE_W ($clog2(N_AGE)),
  .CNT_W (CNT_W)
) u_evr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .lookup_valid (lookup_valid),
  .victim_valid (victim_valid),
  .cnt_clear    (cnt_clear),
  .rd_hit       (rd_hit),
  .rd_reused    (rd_reused),
  .rd_age       (rd_age),
  .rd_count     (rd_count)
);

// File: tb/evict_rank_unit_bench.sv
module evict_rank_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        lookup_valid;
  logic [11:0] cand_age;
  logic [3:0]  cand_reused;
  logic        victim_valid;
  logic [1:0]  victim_idx;
  logic        prio_wr_en;
  logic        prio_wr_reused;
  logic [2:0]  prio_wr_age;
  logic [7:0]  prio_wr_data;
  logic        evt_valid;
  logic        evt_hit;
  logic        evt_reused;
  logic [2:0]  evt_age;
  logic        cnt_clear;
  logic        rd_hit;
  logic        rd_reused;
  logic [2:0]  rd_age;
  logic [15:0] rd_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  evict_rank_unit u_evict_rank_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .lookup_valid   (lookup_valid),
    .cand_age       (cand_age),
    .cand_reused    (cand_reused),
    .victim_valid   (victim_valid),
    .victim_idx     (victim_idx),
    .prio_wr_en     (prio_wr_en),
    .prio_wr_reused (prio_wr_reused),
    .prio_wr_age    (prio_wr_age),
    .prio_wr_data   (prio_wr_data),
    .evt_valid      (evt_valid),
    .evt_hit        (evt_hit),
    .evt_reused     (evt_reused),
    .evt_age        (evt_age),
    .cnt_clear      (cnt_clear),
    .rd_hit         (rd_hit),
    .rd_reused      (rd_reused),
    .rd_age         (rd_age),
    .rd_count       (rd_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic read_cnt(input bit hit, input bit reused, input int age, output int val);
    rd_hit    = hit;
    rd_reused = reused;
    rd_age    = 3'(age);
    #1;
    val = int'(rd_count);
  endtask

  task automatic write_prio(input bit reused, input int age, input int data);
    @(negedge clk);
    prio_wr_en     = 1'b1;
    prio_wr_reused = reused;
    prio_wr_age    = 3'(age);
    prio_wr_data   = 8'(data);
    @(negedge clk);
    prio_wr_en     = 1'b0;
  endtask

  // Drive one lookup; return victim index seen one cycle later.
  task automatic lookup(input int a0, a1, a2, a3, input logic [3:0] cls,
                        input bit also_write, input bit wr_cls, input int wr_age,
                        input int wr_data, output int idx);
    @(negedge clk);
    lookup_valid = 1'b1;
    cand_age     = {3'(a3), 3'(a2), 3'(a1), 3'(a0)};
    cand_reused  = cls;
    if (also_write) begin
      prio_wr_en     = 1'b1;
      prio_wr_reused = wr_cls;
      prio_wr_age    = 3'(wr_age);
      prio_wr_data   = 8'(wr_data);
    end
    @(negedge clk);
    lookup_valid = 1'b0;
    prio_wr_en   = 1'b0;
    check("R2 valid after lookup", int'(victim_valid), 1);
    idx = int'(victim_idx);
    @(negedge clk);
    check("R2 valid drops", int'(victim_valid), 0);
  endtask

  task automatic t_reset();
    int v;
    check("R1 victim_valid", int'(victim_valid), 0);
    check("R1 victim_idx", int'(victim_idx), 0);
    read_cnt(1'b1, 1'b1, 7, v);
    check("R1 counter", v, 0);
    read_cnt(1'b0, 1'b0, 0, v);
    check("R1 counter", v, 0);
  endtask

  task automatic t_counters();
    int v;
    @(negedge clk);
    evt_valid = 1'b1; evt_hit = 1'b1; evt_reused = 1'b0; evt_age = 3'd4;
    @(negedge clk);
    evt_hit = 1'b0; evt_reused = 1'b1; evt_age = 3'd4;
    @(negedge clk);
    evt_hit = 1'b0; evt_reused = 1'b1; evt_age = 3'd4;
    @(negedge clk);
    evt_valid = 1'b0;
    read_cnt(1'b1, 1'b0, 4, v);
    check("R7 hit nonreused age4", v, 1);
    read_cnt(1'b0, 1'b1, 4, v);
    check("R7 evict reused age4", v, 2);
    read_cnt(1'b1, 1'b1, 4, v);
    check("R7 untouched neighbour", v, 0);
    read_cnt(1'b0, 1'b0, 4, v);
    check("R10 select other counter", v, 0);
  endtask

  task automatic t_clear();
    int v;
    @(negedge clk);
    cnt_clear = 1'b1;
    evt_valid = 1'b1; evt_hit = 1'b1; evt_reused = 1'b0; evt_age = 3'd4;
    @(negedge clk);
    cnt_clear = 1'b0;
    evt_valid = 1'b0;
    read_cnt(1'b1, 1'b0, 4, v);
    check("R9 clear beats event", v, 0);
    read_cnt(1'b0, 1'b1, 4, v);
    check("R9 clear all", v, 0);
  endtask

  task automatic t_saturate();
    int v;
    rd_hit = 1'b1; rd_reused = 1'b1; rd_age = 3'd6;
    @(negedge clk);
    evt_valid = 1'b1; evt_hit = 1'b1; evt_reused = 1'b1; evt_age = 3'd6;
    repeat (65535) @(negedge clk);
    evt_valid = 1'b0;
    read_cnt(1'b1, 1'b1, 6, v);
    check("R7 count reaches max", v, 65535);
    @(negedge clk);
    evt_valid = 1'b1;
    repeat (5) @(negedge clk);
    evt_valid = 1'b0;
    read_cnt(1'b1, 1'b1, 6, v);
    check("R8 saturated", v, 65535);
    @(negedge clk);
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    read_cnt(1'b1, 1'b1, 6, v);
    check("R9 clear after read-out", v, 0);
  endtask

  task automatic t_rank();
    int idx;
    // all-zero table: every candidate ties, index 0 wins
    lookup(1, 2, 3, 4, 4'b0000, 0, 0, 0, 0, idx);
    check("R4 all tie", idx, 0);
    write_prio(0, 1, 9);
    write_prio(0, 7, 2);
    write_prio(0, 5, 13);
    write_prio(0, 3, 6);
    lookup(1, 7, 5, 3, 4'b0000, 0, 0, 0, 0, idx);
    check("R3 largest priority", idx, 2);
    lookup(3, 7, 1, 5, 4'b0000, 0, 0, 0, 0, idx);
    check("R3 reordered", idx, 3);
    lookup(2, 5, 2, 5, 4'b0000, 0, 0, 0, 0, idx);
    check("R4 tie lowest index", idx, 1);
  endtask

  task automatic t_class();
    int idx;
    write_prio(1, 2, 200);
    write_prio(0, 2, 5);
    lookup(2, 2, 0, 0, 4'b0010, 0, 0, 0, 0, idx);
    check("R5 reused entry chosen", idx, 1);
    lookup(2, 2, 0, 0, 4'b0001, 0, 0, 0, 0, idx);
    check("R5 class follows candidate", idx, 0);
  endtask

  task automatic t_same_cycle();
    int idx;
    // candidates: age1=9, age5=13, age3=6, age6 non-reused=0
    lookup(1, 5, 3, 6, 4'b0000, 1, 0, 6, 250, idx);
    check("R6 old table used", idx, 1);
    lookup(1, 5, 3, 6, 4'b0000, 0, 0, 0, 0, idx);
    check("R6 new entry visible", idx, 3);
  endtask

  initial begin
    rst_n = 1'b0;
    lookup_valid = 1'b0; cand_age = '0; cand_reused = '0;
    prio_wr_en = 1'b0; prio_wr_reused = 1'b0; prio_wr_age = '0; prio_wr_data = '0;
    evt_valid = 1'b0; evt_hit = 1'b0; evt_reused = 1'b0; evt_age = '0;
    cnt_clear = 1'b0; rd_hit = 1'b0; rd_reused = 1'b0; rd_age = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counters();
    t_clear();
    t_saturate();
    t_rank();
    t_class();
    t_same_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule